// File: doc/BRIEF.md
# Service Discharge Trigger Arbiter

This block decides which of five possible initiators gets to run the single service-discharge job. There are four request strobes: station, cloud, shipping preset and warehouse batch. The fifth initiator is a local push button. The push button is not a clean strobe. It must be held down for a long time and then confirmed separately, and a lock input driven by remote control can shut it out. A start is accepted only while the external thermal and health envelope check reports OK. Once a job runs, a request from a more important source takes over the job and reports itself as the preemptor. Requests of the same or lesser rank are refused as busy.

When the job finishes, a cooldown window counted in ticks blocks any new start. This stops an accidental immediate re-trigger. Every refusal leaves the block as a one-cycle strobe with a reason code.

The arbiter runs three named states: Idle, Running and Cooldown. The transitions are:
- Idle to Running on an accepted start.
- Running to Running when a job is taken over.
- Running to Cooldown on job completion.
- Cooldown to Idle when the cooldown count expires.

The button front end runs four named states: Rest, Holding, Armed and Await-release. The transitions are:
- Rest to Holding when the button level goes high.
- Holding to Rest if the level drops.
- Holding to Armed after the long-press count.
- Armed to Await-release on confirm, which fires a request, or on timeout, which cancels it.
- Await-release to Rest once the level is low.

Top module: `trigger_arbiter`

## Requirements
- R1: Out of reset, `grant_active` is 0, `grant_id` is 7 (none), `preempt_stb` and `reject_stb` are 0, `preempt_id` is 7 and `reject_code` is 0.
- R2: Source IDs are: station 0, cloud 1, shipping 2, batch 3, button 4. A lower ID means higher rank. When several requests arrive in one cycle, only the lowest ID is evaluated. The others are dropped without any strobe.
- R3: In Idle, an accepted request sets `grant_active` to 1 and `grant_id` to its ID at the same clock edge that samples it. These values hold until job completion or a takeover. `grant_id` is 7 exactly when no job runs.
- R4: A request that would start a job or take one over while `env_ok` is low is refused with code 1. The current grant stays unchanged.
- R5: While Running, a request with a lower ID than `grant_id` and with `env_ok` high replaces the grant at the sampling edge. At that edge `preempt_stb` pulses for one cycle with `preempt_id` set to the new ID, and `grant_active` stays 1.
- R6: While Running, a request whose ID is equal to or higher than `grant_id` is refused with code 0 (busy).
- R7: `job_done` while Running drops `grant_active` at the next edge and sets `grant_id` to 7. The block then stays in Cooldown for `COOL_TICKS` ticks. A request in Cooldown, or in the same cycle as `job_done`, is refused with code 2. After Cooldown, requests are granted again.
- R8: The button arms only after its level is sampled high on every clock for `LONG_TICKS` ticks. A shorter press leaves no armed state, so a later confirm does nothing.
- R9: A confirm while Armed turns into a button request that the arbiter evaluates one clock after the confirm is sampled.
- R10: If no confirm arrives within `CONF_TICKS` ticks of arming, the pending press is cancelled. Later confirms are ignored until the level has gone low and a new long press completes.
- R11: A button request evaluated in Idle while `btn_lock` is high is refused with code 3.
- R12: `preempt_stb` and `reject_stb` are registered one-cycle strobes and never assert together. `preempt_id` reads 7 and `reject_code` reads 0 whenever their strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time base enable for all tick counts |
| src_req | input | 4 | Request strobes: bit0 station, bit1 cloud, bit2 shipping, bit3 batch |
| btn_raw | input | 1 | Raw push-button level |
| btn_confirm | input | 1 | Confirm strobe for the button path |
| btn_lock | input | 1 | Remote lockout of the button |
| env_ok | input | 1 | Thermal and health envelope check passed |
| job_done | input | 1 | Running job has finished |
| grant_active | output | 1 | A job is running |
| grant_id | output | 3 | ID of the running source, 7 if none |
| preempt_stb | output | 1 | One-cycle takeover strobe |
| preempt_id | output | 3 | ID of the taking-over source during the strobe |
| reject_stb | output | 1 | One-cycle refusal strobe |
| reject_code | output | 2 | 0 busy, 1 envelope, 2 cooldown, 3 locked |

## Verification
Each of the four strobed sources produces its grant, takeover or refusal at the first clock edge that samples the request. A button confirm produces its result one edge later. `job_done` clears the grant at its sampling edge. The bench drives inputs on falling edges and reads outputs on the next falling edge, which is the first point where each of those results is due; for a confirm it waits two falling edges. A behavioural model updated on every rising edge is compared against all outputs on every falling edge, so results are checked both early and late.

// File: rtl/trg_arb_pkg.sv
package trg_arb_pkg;

    localparam int SRC_N   = 5;
    localparam int ID_W    = 3;
    localparam int EXT_N   = SRC_N - 1;

    typedef logic [ID_W-1:0] src_id_t;

    localparam src_id_t ID_NONE   = 3'd7;
    localparam src_id_t ID_BUTTON = 3'd4;

    typedef enum logic [1:0] {
        RJ_BUSY = 2'd0,
        RJ_ENV  = 2'd1,
        RJ_COOL = 2'd2,
        RJ_LOCK = 2'd3
    } rej_t;

    typedef enum logic [1:0] {
        ARB_IDLE    = 2'd0,
        ARB_RUNNING = 2'd1,
        ARB_COOL    = 2'd2
    } arb_st_t;

    typedef enum logic [1:0] {
        BP_REST    = 2'd0,
        BP_HOLDING = 2'd1,
        BP_ARMED   = 2'd2,
        BP_AWAIT   = 2'd3
    } btn_st_t;

endpackage

// File: rtl/trg_prio_pick.sv
module trg_prio_pick #(
    parameter int N  = 5,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          hit_any,
    output logic [IW-1:0] hit_id
);

    logic [N:0]   seen;
    logic [N-1:0] hit;

    assign seen[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_chain
            assign hit[g]    = req[g] & ~seen[g];
            assign seen[g+1] = seen[g] | req[g];
        end
    endgenerate

    assign hit_any = seen[N];

    always_comb begin
        hit_id = '0;
        for (int i = 0; i < N; i++) begin
            if (hit[i]) hit_id = hit_id | IW'(i);
        end
    end

endmodule

// File: rtl/trg_btn_path.sv
module trg_btn_path
    import trg_arb_pkg::*;
#(
    parameter int LONG_TICKS = 8,
    parameter int CONF_TICKS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    input  logic confirm,
    output logic fire
);

    localparam int MAXT = (LONG_TICKS > CONF_TICKS) ? LONG_TICKS : CONF_TICKS;
    localparam int CW   = $clog2(MAXT + 1);
    localparam logic [CW-1:0] LONG_LAST = CW'(LONG_TICKS - 1);
    localparam logic [CW-1:0] CONF_LAST = CW'(CONF_TICKS - 1);

    btn_st_t        st, st_n;
    logic [CW-1:0]  cnt, cnt_n;
    logic           fire_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= BP_REST;
            cnt  <= '0;
            fire <= 1'b0;
        end else begin
            st   <= st_n;
            cnt  <= cnt_n;
            fire <= fire_n;
        end
    end

    // transitions and outputs
    always_comb begin
        st_n   = st;
        cnt_n  = cnt;
        fire_n = 1'b0;
        unique case (st)
            BP_REST: begin
                if (raw) begin
                    st_n  = BP_HOLDING;
                    cnt_n = '0;
                end
            end
            BP_HOLDING: begin
                if (!raw) begin
                    st_n = BP_REST;
                end else if (tick) begin
                    if (cnt == LONG_LAST) begin
                        st_n  = BP_ARMED;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            BP_ARMED: begin
                if (confirm) begin
                    fire_n = 1'b1;
                    st_n   = BP_AWAIT;
                end else if (tick) begin
                    if (cnt == CONF_LAST) st_n = BP_AWAIT;
                    else                  cnt_n = cnt + 1'b1;
                end
            end
            BP_AWAIT: begin
                if (!raw) st_n = BP_REST;
            end
            default: st_n = BP_REST;
        endcase
    end

endmodule

// File: rtl/trg_arb_core.sv
module trg_arb_core
    import trg_arb_pkg::*;
#(
    parameter int COOL_TICKS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        win_any,
    input  src_id_t     win_id,
    input  logic        lock,
    input  logic        env_ok,
    input  logic        job_done,
    output logic        grant_active,
    output src_id_t     grant_id,
    output logic        preempt_stb,
    output src_id_t     preempt_id,
    output logic        reject_stb,
    output logic [1:0]  reject_code
);

    localparam int CW = $clog2(COOL_TICKS + 1);
    localparam logic [CW-1:0] COOL_LAST = CW'(COOL_TICKS - 1);

    arb_st_t        st, st_n;
    logic [CW-1:0]  cnt, cnt_n;
    src_id_t        gid_n, pid_n;
    logic           pre_n, rej_n;
    rej_t           code_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ARB_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_active <= 1'b0;
            grant_id     <= ID_NONE;
            preempt_stb  <= 1'b0;
            preempt_id   <= ID_NONE;
            reject_stb   <= 1'b0;
            reject_code  <= 2'd0;
        end else begin
            grant_active <= (st_n == ARB_RUNNING);
            grant_id     <= gid_n;
            preempt_stb  <= pre_n;
            preempt_id   <= pid_n;
            reject_stb   <= rej_n;
            reject_code  <= code_n;
        end
    end

    // transitions
    always_comb begin
        st_n   = st;
        cnt_n  = cnt;
        gid_n  = grant_id;
        pre_n  = 1'b0;
        pid_n  = ID_NONE;
        rej_n  = 1'b0;
        code_n = RJ_BUSY;
        unique case (st)
            ARB_IDLE: begin
                if (win_any) begin
                    if (win_id == ID_BUTTON && lock) begin
                        rej_n  = 1'b1;
                        code_n = RJ_LOCK;
                    end else if (!env_ok) begin
                        rej_n  = 1'b1;
                        code_n = RJ_ENV;
                    end else begin
                        st_n  = ARB_RUNNING;
                        gid_n = win_id;
                    end
                end
            end
            ARB_RUNNING: begin
                if (job_done) begin
                    st_n  = ARB_COOL;
                    cnt_n = '0;
                    gid_n = ID_NONE;
                    if (win_any) begin
                        rej_n  = 1'b1;
                        code_n = RJ_COOL;
                    end
                end else if (win_any) begin
                    if (win_id < grant_id) begin
                        if (env_ok) begin
                            pre_n = 1'b1;
                            pid_n = win_id;
                            gid_n = win_id;
                        end else begin
                            rej_n  = 1'b1;
                            code_n = RJ_ENV;
                        end
                    end else begin
                        rej_n  = 1'b1;
                        code_n = RJ_BUSY;
                    end
                end
            end
            ARB_COOL: begin
                if (win_any) begin
                    rej_n  = 1'b1;
                    code_n = RJ_COOL;
                end
                if (tick) begin
                    if (cnt == COOL_LAST) st_n = ARB_IDLE;
                    else                  cnt_n = cnt + 1'b1;
                end
            end
            default: st_n = ARB_IDLE;
        endcase
    end

endmodule

// File: rtl/trigger_arbiter.sv
module trigger_arbiter
    import trg_arb_pkg::*;
#(
    parameter int LONG_TICKS = 8,
    parameter int CONF_TICKS = 6,
    parameter int COOL_TICKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [EXT_N-1:0]  src_req,
    input  logic              btn_raw,
    input  logic              btn_confirm,
    input  logic              btn_lock,
    input  logic              env_ok,
    input  logic              job_done,
    output logic              grant_active,
    output logic [ID_W-1:0]   grant_id,
    output logic              preempt_stb,
    output logic [ID_W-1:0]   preempt_id,
    output logic              reject_stb,
    output logic [1:0]        reject_code
);

    logic              btn_fire;
    logic [SRC_N-1:0]  req_vec;
    logic              win_any;
    src_id_t           win_id;

    assign req_vec = {btn_fire, src_req};

    trg_btn_path #(
        .LONG_TICKS (LONG_TICKS),
        .CONF_TICKS (CONF_TICKS)
    ) u_btn (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .raw     (btn_raw),
        .confirm (btn_confirm),
        .fire    (btn_fire)
    );

    trg_prio_pick #(
        .N  (SRC_N),
        .IW (ID_W)
    ) u_pick (
        .req     (req_vec),
        .hit_any (win_any),
        .hit_id  (win_id)
    );

    trg_arb_core #(
        .COOL_TICKS (COOL_TICKS)
    ) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .win_any      (win_any),
        .win_id       (win_id),
        .lock         (btn_lock),
        .env_ok       (env_ok),
        .job_done     (job_done),
        .grant_active (grant_active),
        .grant_id     (grant_id),
        .preempt_stb  (preempt_stb),
        .preempt_id   (preempt_id),
        .reject_stb   (reject_stb),
        .reject_code  (reject_code)
    );

endmodule

// File: rtl/trigger_arbiter_chk.sv
module trigger_arbiter_chk
    import trg_arb_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        btn_lock,
    input logic        env_ok,
    input logic        job_done,
    input logic        grant_active,
    input logic [2:0]  grant_id,
    input logic        preempt_stb,
    input logic [2:0]  preempt_id,
    input logic        reject_stb,
    input logic [1:0]  reject_code
);

    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reject_stb && preempt_stb));

    // R12
    quiet_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!preempt_stb |-> preempt_id == ID_NONE) and (!reject_stb |-> reject_code == 2'd0));

    // R3
    none_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_active == (grant_id != ID_NONE));

    // R4
    env_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_active) |-> $past(env_ok));

    // R5
    preempt_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preempt_stb |-> (grant_active && $past(grant_active) &&
                         grant_id == preempt_id && preempt_id < $past(grant_id) && $past(env_ok)));

    // R7
    drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grant_active) |-> $past(job_done));

    // R7
    cool_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grant_active) |=> !grant_active);

    // R11
    lock_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reject_stb && reject_code == 2'd3) |-> $past(btn_lock));

endmodule

bind trigger_arbiter trigger_arbiter_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .btn_lock     (btn_lock),
    .env_ok       (env_ok),
    .job_done     (job_done),
    .grant_active (grant_active),
    .grant_id     (grant_id),
    .preempt_stb  (preempt_stb),
    .preempt_id   (preempt_id),
    .reject_stb   (reject_stb),
    .reject_code  (reject_code)
);

// File: tb/sim_trigger_arbiter.sv
`timescale 1ns/1ps
module sim_trigger_arbiter;

    localparam int LONG_T = 8;
    localparam int CONF_T = 6;
    localparam int COOL_T = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] src_req = '0;
    logic       btn_raw = 1'b0;
    logic       btn_confirm = 1'b0;
    logic       btn_lock = 1'b0;
    logic       env_ok = 1'b0;
    logic       job_done = 1'b0;
    logic       grant_active;
    logic [2:0] grant_id;
    logic       preempt_stb;
    logic [2:0] preempt_id;
    logic       reject_stb;
    logic [1:0] reject_code;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    finished = 1'b0;
    string cur_tag  = "R1";

    always #2.5 clk = ~clk;

    always @(negedge clk) tick <= rst_n ? ~tick : 1'b0;

    trigger_arbiter #(
        .LONG_TICKS (LONG_T),
        .CONF_TICKS (CONF_T),
        .COOL_TICKS (COOL_T)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .src_req      (src_req),
        .btn_raw      (btn_raw),
        .btn_confirm  (btn_confirm),
        .btn_lock     (btn_lock),
        .env_ok       (env_ok),
        .job_done     (job_done),
        .grant_active (grant_active),
        .grant_id     (grant_id),
        .preempt_stb  (preempt_stb),
        .preempt_id   (preempt_id),
        .reject_stb   (reject_stb),
        .reject_code  (reject_code)
    );

    // behavioural reference: mode 0 idle, 1 running, 2 cooling
    int m_mode = 0, m_owner = 7, m_cool = 0;
    int m_pre = 0, m_pid = 7, m_rej = 0, m_code = 0;
    int p_phase = 0, p_count = 0, p_fire = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_owner = 7; m_cool = 0;
            m_pre = 0; m_pid = 7; m_rej = 0; m_code = 0;
            p_phase = 0; p_count = 0; p_fire = 0;
        end else begin
            int best;
            int next_fire;
            best = -1;
            for (int s = 0; s < 5; s++) begin
                if (best < 0 && ((s < 4) ? (src_req[s] == 1'b1) : (p_fire == 1))) best = s;
            end
            m_pre = 0; m_pid = 7; m_rej = 0; m_code = 0;
            if (m_mode == 0) begin
                if (best >= 0) begin
                    if (best == 4 && btn_lock) begin m_rej = 1; m_code = 3; end
                    else if (!env_ok)          begin m_rej = 1; m_code = 1; end
                    else begin m_mode = 1; m_owner = best; end
                end
            end else if (m_mode == 1) begin
                if (job_done) begin
                    m_mode = 2; m_cool = 0; m_owner = 7;
                    if (best >= 0) begin m_rej = 1; m_code = 2; end
                end else if (best >= 0) begin
                    if (best < m_owner && env_ok) begin m_pre = 1; m_pid = best; m_owner = best; end
                    else if (best < m_owner)      begin m_rej = 1; m_code = 1; end
                    else                          begin m_rej = 1; m_code = 0; end
                end
            end else begin
                if (best >= 0) begin m_rej = 1; m_code = 2; end
                if (tick) begin
                    if (m_cool + 1 >= COOL_T) m_mode = 0;
                    else m_cool++;
                end
            end
            // button path: 0 rest, 1 holding, 2 armed, 3 waiting for release
            next_fire = 0;
            case (p_phase)
                0: if (btn_raw) begin p_phase = 1; p_count = 0; end
                1: if (!btn_raw) p_phase = 0;
                   else if (tick) begin
                       p_count++;
                       if (p_count >= LONG_T) begin p_phase = 2; p_count = 0; end
                   end
                2: if (btn_confirm) begin next_fire = 1; p_phase = 3; end
                   else if (tick) begin
                       p_count++;
                       if (p_count >= CONF_T) p_phase = 3;
                   end
                default: if (!btn_raw) p_phase = 0;
            endcase
            p_fire = next_fire;
        end
    end

    // cycle compare
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            n_checks++;
            if (grant_active !== (m_mode == 1) || grant_id !== 3'(m_owner) ||
                preempt_stb !== m_pre[0] || preempt_id !== 3'(m_pid) ||
                reject_stb !== m_rej[0] || reject_code !== 2'(m_code)) begin
                n_fails++;
                $display("FAIL %s cycle compare actual=%0d/%0d/%0d/%0d/%0d/%0d expected=%0d/%0d/%0d/%0d/%0d/%0d",
                         cur_tag, grant_active, grant_id, preempt_stb, preempt_id, reject_stb, reject_code,
                         (m_mode == 1), m_owner, m_pre, m_pid, m_rej, m_code);
            end
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req(input logic [3:0] bits);
        src_req = bits;
        @(negedge clk);
        src_req = '0;
    endtask

    task automatic confirm_pulse();
        btn_confirm = 1'b1;
        @(negedge clk);
        btn_confirm = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_job();
        job_done = 1'b1;
        @(negedge clk);
        job_done = 1'b0;
        cyc(12);
    endtask

    initial begin
        cyc(3);
        chk("R1", "grant_active", grant_active, 0);
        chk("R1", "grant_id", grant_id, 7);
        chk("R1", "preempt_id", preempt_id, 7);
        chk("R1", "reject_stb", reject_stb, 0);
        rst_n = 1'b1;
        cyc(2);
        chk("R1", "idle grant_id", grant_id, 7);

        cur_tag = "R3"; env_ok = 1'b1;
        pulse_req(4'b0100);
        chk("R3", "grant_active", grant_active, 1);
        chk("R3", "grant_id", grant_id, 2);
        cyc(3);
        chk("R3", "held grant_id", grant_id, 2);

        cur_tag = "R6";
        pulse_req(4'b1000);
        chk("R6", "lower busy stb", reject_stb, 1);
        chk("R6", "lower busy code", reject_code, 0);
        pulse_req(4'b0100);
        chk("R6", "equal busy code", reject_code, 0);
        chk("R6", "grant kept", grant_id, 2);

        cur_tag = "R5";
        pulse_req(4'b0010);
        chk("R5", "preempt_stb", preempt_stb, 1);
        chk("R5", "preempt_id", preempt_id, 1);
        chk("R5", "grant_id", grant_id, 1);
        cyc(1);
        chk("R12", "preempt strobe width", preempt_stb, 0);

        cur_tag = "R4"; env_ok = 1'b0;
        pulse_req(4'b0001);
        chk("R4", "env code", reject_code, 1);
        chk("R4", "grant kept", grant_id, 1);
        env_ok = 1'b1;

        cur_tag = "R7";
        job_done = 1'b1; src_req = 4'b0001;
        @(negedge clk);
        job_done = 1'b0; src_req = '0;
        chk("R7", "grant dropped", grant_active, 0);
        chk("R7", "grant_id none", grant_id, 7);
        chk("R7", "same-cycle cool code", reject_code, 2);
        cyc(2);
        pulse_req(4'b0001);
        chk("R7", "cooldown code", reject_code, 2);
        chk("R7", "no grant in cooldown", grant_active, 0);
        cyc(12);

        cur_tag = "R2";
        pulse_req(4'b1001);
        chk("R2", "lowest id wins", grant_id, 0);
        chk("R2", "no reject for loser", reject_stb, 0);
        chk("R7", "grant after cooldown", grant_active, 1);
        finish_job();

        cur_tag = "R4"; env_ok = 1'b0;
        pulse_req(4'b0100);
        chk("R4", "idle env code", reject_code, 1);
        chk("R4", "idle no grant", grant_active, 0);
        env_ok = 1'b1;

        cur_tag = "R8";
        btn_raw = 1'b1; cyc(3); btn_raw = 1'b0; cyc(2);
        confirm_pulse();
        chk("R8", "short press no grant", grant_active, 0);
        chk("R8", "short press no reject", reject_stb, 0);

        cur_tag = "R9";
        btn_raw = 1'b1; cyc(20);
        confirm_pulse();
        chk("R9", "button grant", grant_active, 1);
        chk("R9", "button id", grant_id, 4);
        btn_raw = 1'b0;
        cur_tag = "R5";
        pulse_req(4'b1000);
        chk("R5", "batch over button", preempt_id, 3);
        finish_job();

        cur_tag = "R10";
        btn_raw = 1'b1; cyc(20); cyc(16);
        confirm_pulse();
        chk("R10", "late confirm no grant", grant_active, 0);
        chk("R10", "late confirm no reject", reject_stb, 0);
        btn_raw = 1'b0; cyc(2);

        cur_tag = "R11"; btn_lock = 1'b1;
        btn_raw = 1'b1; cyc(20);
        confirm_pulse();
        chk("R11", "locked code", reject_code, 3);
        chk("R11", "locked no grant", grant_active, 0);
        btn_raw = 1'b0; btn_lock = 1'b0;
        cyc(4);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule